// File: doc/BRIEF.md
# Paired-Word Vector Logic Unit

This block is a single-stage execution slice for a vector datapath that views each 64-bit operand as a pair of 32-bit lanes: a high lane (bits 63:32) and a low lane (bits 31:0). A 7-bit operation select picks one of seven functions. One function is a full-width exclusive-or. Four functions build the result by taking one word from operand A and one word from operand B. Two functions shift each lane right independently, in signed or unsigned form.

An issuing stage presents the operation, both operands and a valid strobe in the same cycle. The registered result, an illegal-operation flag and an output valid appear on the following clock edge. The result register loads only when an operation is issued. Otherwise it holds its last value. An operation code outside the supported set gives a zero result and raises the illegal flag.

The operation select carries the low seven bits of the instruction's extended opcode. The seven supported codes are therefore the decimal values 22, 44, 45, 46, 47, 33 and 32.

Top module: `pwv_logic_unit`

## Requirements
- R1: Code 22 gives the bitwise exclusive-or of the full 64-bit operands A and B.
- R2: Code 44 places A[63:32] in result[63:32] and B[63:32] in result[31:0].
- R3: Code 45 places A[31:0] in result[63:32] and B[31:0] in result[31:0].
- R4: Code 46 places A[63:32] in result[63:32] and B[31:0] in result[31:0].
- R5: Code 47 places A[31:0] in result[63:32] and B[63:32] in result[31:0].
- R6: Code 33 shifts each lane of A right arithmetically, filling with that lane's sign bit. The high lane shifts by B[36:32] and the low lane by B[4:0]. All other bits of B have no effect on the result.
- R7: Code 32 shifts each lane of A right logically, filling with zeros. The shift amounts come from B[36:32] for the high lane and B[4:0] for the low lane. All other bits of B have no effect on the result.
- R8: Any code other than the seven above gives a zero result with illegal_op at 1. Each of the seven supported codes gives illegal_op at 0.
- R9: When in_valid is high at a rising clock edge, the result, illegal_op and out_valid reflect that operation after that edge. out_valid is 1 for exactly the cycle that follows each issue, so back-to-back issues produce back-to-back results.
- R10: When in_valid is low at a rising clock edge, result and illegal_op keep their values and out_valid goes to 0, whatever is on op_sel, opnd_a and opnd_b.
- R11: While rst_n is low, result, illegal_op and out_valid are 0. They clear as soon as rst_n falls, and the block accepts work from the third rising edge after rst_n rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Issues the operation present on op_sel, opnd_a and opnd_b |
| op_sel | input | 7 | Operation code (low seven bits of the extended opcode) |
| opnd_a | input | 64 | Operand A, high lane in bits 63:32 |
| opnd_b | input | 64 | Operand B, also the source of the per-lane shift amounts |
| out_valid | output | 1 | High for the cycle after an issue |
| result | output | 64 | Registered result |
| illegal_op | output | 1 | Registered flag for an unsupported operation code |

## Verification
The bench aims at the lane crossings in the four merge codes. A design that swaps which word of A or B feeds a lane gives a result whose halves match the wrong input words. For the shifts, the vectors combine a negative high lane shifted by 31, a shift amount of zero, and B lanes whose bits above bit 4 are set. A design that takes the count from a single lane, widens the count field, or fills with the wrong bit gives a different lane value in at least one of these cases. Codes just outside the merge range and at the ends of the code space check that the decode is exact; a loose decode would return merge data or clear the illegal flag. Back-to-back issue, idle cycles with changing inputs, and a reset in the middle of the run check that the register loads only on issue and clears at once on reset.

// File: rtl/pwv_pkg.sv
package pwv_pkg;

  localparam int unsigned OP_W = 7;

  // Operation codes: low seven bits of the extended opcode.
  localparam logic [OP_W-1:0] OPC_XOR     = 7'd22;
  localparam logic [OP_W-1:0] OPC_MRG_HH  = 7'd44;
  localparam logic [OP_W-1:0] OPC_MRG_LL  = 7'd45;
  localparam logic [OP_W-1:0] OPC_MRG_HL  = 7'd46;
  localparam logic [OP_W-1:0] OPC_MRG_LH  = 7'd47;
  localparam logic [OP_W-1:0] OPC_SHR_ARI = 7'd33;
  localparam logic [OP_W-1:0] OPC_SHR_LOG = 7'd32;

  // Result source picked by the decoder.
  typedef enum logic [1:0] {
    SRC_ZERO  = 2'd0,
    SRC_XOR   = 2'd1,
    SRC_MERGE = 2'd2,
    SRC_SHIFT = 2'd3
  } res_src_e;

  typedef struct packed {
    res_src_e src;
    logic     a_take_hi;   // merge: high result lane from A's high word
    logic     b_take_hi;   // merge: low result lane from B's high word
    logic     arith;       // shift: fill with lane sign
    logic     illegal;
  } pwv_ctrl_t;

endpackage

// File: rtl/pwv_decode.sv
module pwv_decode
  import pwv_pkg::*;
(
  input  logic [OP_W-1:0] op_sel,
  output pwv_ctrl_t       ctrl
);

  always_comb begin
    ctrl.src       = SRC_ZERO;
    ctrl.a_take_hi = 1'b0;
    ctrl.b_take_hi = 1'b0;
    ctrl.arith     = 1'b0;
    ctrl.illegal   = 1'b0;
    case (op_sel)
      OPC_XOR: begin
        ctrl.src = SRC_XOR;
      end
      OPC_MRG_HH: begin
        ctrl.src       = SRC_MERGE;
        ctrl.a_take_hi = 1'b1;
        ctrl.b_take_hi = 1'b1;
      end
      OPC_MRG_LL: begin
        ctrl.src = SRC_MERGE;
      end
      OPC_MRG_HL: begin
        ctrl.src       = SRC_MERGE;
        ctrl.a_take_hi = 1'b1;
      end
      OPC_MRG_LH: begin
        ctrl.src       = SRC_MERGE;
        ctrl.b_take_hi = 1'b1;
      end
      OPC_SHR_ARI: begin
        ctrl.src   = SRC_SHIFT;
        ctrl.arith = 1'b1;
      end
      OPC_SHR_LOG: begin
        ctrl.src = SRC_SHIFT;
      end
      default: begin
        ctrl.illegal = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/pwv_merge.sv
module pwv_merge #(
  parameter int unsigned LANE_W = 32
) (
  input  logic [2*LANE_W-1:0] opnd_a,
  input  logic [2*LANE_W-1:0] opnd_b,
  input  logic                a_take_hi,
  input  logic                b_take_hi,
  output logic [2*LANE_W-1:0] merged
);

  logic [LANE_W-1:0] a_hi, a_lo, b_hi, b_lo;

  assign a_hi = opnd_a[2*LANE_W-1:LANE_W];
  assign a_lo = opnd_a[LANE_W-1:0];
  assign b_hi = opnd_b[2*LANE_W-1:LANE_W];
  assign b_lo = opnd_b[LANE_W-1:0];

  // A always feeds the high result lane, B always feeds the low one.
  always_comb begin
    merged[2*LANE_W-1:LANE_W] = a_take_hi ? a_hi : a_lo;
    merged[LANE_W-1:0]        = b_take_hi ? b_hi : b_lo;
  end

endmodule

// File: rtl/pwv_lane_shift.sv
module pwv_lane_shift #(
  parameter int unsigned LANE_W = 32,
  localparam int unsigned SH_W  = $clog2(LANE_W)
) (
  input  logic [LANE_W-1:0] lane_in,
  input  logic [SH_W-1:0]   amount,
  input  logic              arith,
  output logic [LANE_W-1:0] lane_out
);

  logic [LANE_W-1:0] fill_mask;
  logic [LANE_W-1:0] logical;
  logic              sign_bit;

  assign sign_bit  = lane_in[LANE_W-1];
  assign logical   = lane_in >> amount;
  // Ones in the vacated upper positions.
  assign fill_mask = ~({LANE_W{1'b1}} >> amount);

  always_comb begin
    if (arith && sign_bit) begin
      lane_out = logical | fill_mask;
    end else begin
      lane_out = logical;
    end
  end

endmodule

// File: rtl/pwv_rst_sync.sv
module pwv_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/pwv_logic_unit.sv
module pwv_logic_unit
  import pwv_pkg::*;
#(
  parameter int unsigned LANE_W     = 32,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned LANES     = 2,
  localparam int unsigned DATA_W    = LANES * LANE_W,
  localparam int unsigned SH_W      = $clog2(LANE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   op_sel,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              illegal_op
);

  logic              rst_sync_n;
  pwv_ctrl_t         ctrl;
  logic [DATA_W-1:0] merge_out;
  logic [DATA_W-1:0] shift_out;
  logic [DATA_W-1:0] res_d,   res_q;
  logic              ill_d,   ill_q;
  logic              vld_d,   vld_q;
  logic              load_en;

  pwv_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pwv_decode u_decode (
    .op_sel (op_sel),
    .ctrl   (ctrl)
  );

  pwv_merge #(.LANE_W(LANE_W)) u_merge (
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .a_take_hi (ctrl.a_take_hi),
    .b_take_hi (ctrl.b_take_hi),
    .merged    (merge_out)
  );

  // One shifter per lane; each lane's count comes from the same lane of B.
  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    pwv_lane_shift #(.LANE_W(LANE_W)) u_shift (
      .lane_in  (opnd_a[ln*LANE_W +: LANE_W]),
      .amount   (opnd_b[ln*LANE_W +: SH_W]),
      .arith    (ctrl.arith),
      .lane_out (shift_out[ln*LANE_W +: LANE_W])
    );
  end

  // Next-state logic
  assign load_en = in_valid;

  always_comb begin
    unique case (ctrl.src)
      SRC_XOR:   res_d = opnd_a ^ opnd_b;
      SRC_MERGE: res_d = merge_out;
      SRC_SHIFT: res_d = shift_out;
      default:   res_d = '0;
    endcase
    ill_d = ctrl.illegal;
    vld_d = in_valid;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_q <= '0;
      ill_q <= 1'b0;
    end else if (load_en) begin
      res_q <= res_d;
      ill_q <= ill_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  assign result     = res_q;
  assign illegal_op = ill_q;
  assign out_valid  = vld_q;

endmodule

// File: rtl/pwv_logic_unit_chk.sv
module pwv_logic_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [6:0]  op_sel,
  input logic [63:0] opnd_a,
  input logic [63:0] opnd_b,
  input logic        out_valid,
  input logic [63:0] result,
  input logic        illegal_op
);

  logic legal_code;
  assign legal_code = (op_sel == 7'd22) || (op_sel == 7'd44) || (op_sel == 7'd45) ||
                      (op_sel == 7'd46) || (op_sel == 7'd47) || (op_sel == 7'd33) ||
                      (op_sel == 7'd32);

  // R1
  assert_xor_full_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 7'd22) |=> (result == ($past(opnd_a) ^ $past(opnd_b))));

  // R2
  assert_merge_hh_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 7'd44) |=>
      (result == {$past(opnd_a[63:32]), $past(opnd_b[63:32])}));

  // R3
  assert_merge_ll_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 7'd45) |=>
      (result == {$past(opnd_a[31:0]), $past(opnd_b[31:0])}));

  // R6
  assert_sra_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 7'd33 && opnd_a[63]) |=> result[63]);

  // R7
  assert_srl_zero_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 7'd32 && opnd_b[36:32] != 5'd0) |=> !result[63]);

  // R8
  assert_illegal_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !legal_code) |=> (illegal_op && result == 64'd0));

  assert_legal_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && legal_code) |=> !illegal_op);

  // R9
  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R10
  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result) && $stable(illegal_op)));

endmodule

bind pwv_logic_unit pwv_logic_unit_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .in_valid   (in_valid),
  .op_sel     (op_sel),
  .opnd_a     (opnd_a),
  .opnd_b     (opnd_b),
  .out_valid  (out_valid),
  .result     (result),
  .illegal_op (illegal_op)
);

// File: tb/tb_pwv_logic_unit.sv
module tb_pwv_logic_unit;

  typedef struct packed {
    logic [6:0]  op;
    logic [63:0] a;
    logic [63:0] b;
    int unsigned req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{7'd22,  64'h0123456789ABCDEF, 64'hFFFF0000F0F0F0F0, 1},   // R1
    '{7'd22,  64'hFFFFFFFFFFFFFFFF, 64'h5555AAAA0000FFFF, 1},   // R1
    '{7'd44,  64'hAAAA1111BBBB2222, 64'hCCCC3333DDDD4444, 2},   // R2
    '{7'd45,  64'hAAAA1111BBBB2222, 64'hCCCC3333DDDD4444, 3},   // R3
    '{7'd46,  64'hAAAA1111BBBB2222, 64'hCCCC3333DDDD4444, 4},   // R4
    '{7'd47,  64'hAAAA1111BBBB2222, 64'hCCCC3333DDDD4444, 5},   // R5
    '{7'd33,  64'h800000007FFFFFFF, 64'h0000001F00000004, 6},   // R6 hi by 31
    '{7'd33,  64'hF000000080000001, 64'hFFFFFFE000000021, 6},   // R6 hi by 0, upper B bits ignored
    '{7'd32,  64'h80000000FFFFFFFF, 64'h0000001F00000010, 7},   // R7
    '{7'd32,  64'hDEADBEEFCAFEF00D, 64'h00000040FFFFFFE3, 7},   // R7 hi by 0, lo by 3
    '{7'd0,   64'h1111111111111111, 64'h2222222222222222, 8},   // R8
    '{7'd127, 64'h1111111111111111, 64'h2222222222222222, 8},   // R8
    '{7'd23,  64'hFFFFFFFFFFFFFFFF, 64'h0F0F0F0F0F0F0F0F, 8},   // R8
    '{7'd43,  64'hAAAA1111BBBB2222, 64'hCCCC3333DDDD4444, 8},   // R8
    '{7'd48,  64'hAAAA1111BBBB2222, 64'hCCCC3333DDDD4444, 8}    // R8
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [6:0]  op_sel;
  logic [63:0] opnd_a, opnd_b;
  logic        out_valid;
  logic [63:0] result;
  logic        illegal_op;

  int n_chk  = 0;
  int n_fail = 0;
  logic [63:0] last_res;
  logic        last_ill;

  always #5 clk = ~clk;

  pwv_logic_unit dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .op_sel     (op_sel),
    .opnd_a     (opnd_a),
    .opnd_b     (opnd_b),
    .out_valid  (out_valid),
    .result     (result),
    .illegal_op (illegal_op)
  );

  // Model written from the requirements.
  function automatic logic [64:0] model(input logic [6:0] op, input logic [63:0] a,
                                        input logic [63:0] b);
    logic [31:0] hi, lo;
    logic        ill;
    ill = 1'b0;
    case (op)
      7'd22: {hi, lo} = a ^ b;
      7'd44: begin hi = a[63:32]; lo = b[63:32]; end
      7'd45: begin hi = a[31:0];  lo = b[31:0];  end
      7'd46: begin hi = a[63:32]; lo = b[31:0];  end
      7'd47: begin hi = a[31:0];  lo = b[63:32]; end
      7'd33: begin
        hi = $unsigned($signed(a[63:32]) >>> b[36:32]);
        lo = $unsigned($signed(a[31:0])  >>> b[4:0]);
      end
      7'd32: begin
        hi = a[63:32] >> b[36:32];
        lo = a[31:0]  >> b[4:0];
      end
      default: begin hi = '0; lo = '0; ill = 1'b1; end
    endcase
    return {ill, hi, lo};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue_and_check(input logic [6:0] op, input logic [63:0] a,
                                 input logic [63:0] b, input int unsigned req);
    logic [64:0] e;
    e = model(op, a, b);
    @(negedge clk);
    in_valid = 1'b1; op_sel = op; opnd_a = a; opnd_b = b;
    @(negedge clk);
    in_valid = 1'b0;
    chk($sformatf("R%0d result op=%0d", req, op), result, e[63:0]);
    chk($sformatf("R8 illegal_op op=%0d", op), {63'd0, illegal_op}, {63'd0, e[64]});
    chk("R9 out_valid after issue", {63'd0, out_valid}, 64'd1);
    last_res = e[63:0];
    last_ill = e[64];
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL R9 watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [64:0] e1, e2;
    rst_n = 1'b0; in_valid = 1'b0; op_sel = '0; opnd_a = '0; opnd_b = '0;
    repeat (3) @(negedge clk);
    chk("R11 result in reset", result, 64'd0);
    chk("R11 out_valid in reset", {63'd0, out_valid}, 64'd0);
    chk("R11 illegal_op in reset", {63'd0, illegal_op}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      issue_and_check(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].req);
    end

    // R10: idle cycles with changing inputs leave state alone
    @(negedge clk);
    op_sel = 7'd22; opnd_a = 64'hFFFF_FFFF_FFFF_FFFF; opnd_b = 64'h1;
    @(negedge clk);
    op_sel = 7'd44; opnd_a = 64'h1234;
    @(negedge clk);
    chk("R10 result held while idle", result, last_res);
    chk("R10 illegal_op held while idle", {63'd0, illegal_op}, {63'd0, last_ill});
    chk("R10 out_valid low while idle", {63'd0, out_valid}, 64'd0);

    // R9: back-to-back issue
    e1 = model(7'd46, 64'h0102030405060708, 64'h1112131415161718);
    e2 = model(7'd33, 64'h8000000080000000, 64'h0000000400000008);
    @(negedge clk);
    in_valid = 1'b1; op_sel = 7'd46;
    opnd_a = 64'h0102030405060708; opnd_b = 64'h1112131415161718;
    @(negedge clk);
    chk("R9 first back-to-back result", result, e1[63:0]);
    chk("R9 out_valid first", {63'd0, out_valid}, 64'd1);
    op_sel = 7'd33; opnd_a = 64'h8000000080000000; opnd_b = 64'h0000000400000008;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 second back-to-back result", result, e2[63:0]);
    chk("R9 out_valid second", {63'd0, out_valid}, 64'd1);
    @(negedge clk);
    chk("R9 out_valid drops after one cycle", {63'd0, out_valid}, 64'd0);

    // R11: asynchronous clear mid-run
    issue_and_check(7'd127, 64'h5, 64'h6, 8);
    #2 rst_n = 1'b0;
    #1;
    chk("R11 result clears on reset", result, 64'd0);
    chk("R11 illegal_op clears on reset", {63'd0, illegal_op}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    issue_and_check(7'd47, 64'hAAAA1111BBBB2222, 64'hCCCC3333DDDD4444, 5);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule